// File: doc/BRIEF.md
# Special-Register Access Unit

This unit sits beside a small processor's execute stage and handles the two special-register instructions: move-to and move-from. A 16-bit special-register address arrives with a valid strobe and a write flag. The upper five bits select a register group and the lower eleven bits select an entry within that group. The unit holds these registers:

- the system group;
- the first way of the data and instruction translation match/translate arrays;
- a 64-bit multiply-accumulate register, exposed as two 32-bit halves;
- the interrupt mask and interrupt status.

Timer accesses are forwarded to a separate timer block.

Reads are combinational. A read of an address with no register behind it returns the destination register's previous value. That value is supplied on `acc_dest_old`, so the pipeline can always write back the result.

Some writes have side effects on the rest of the core. The unit reports each one as a one-cycle pulse in the cycle after the write:

- a full translation-buffer flush;
- a single-page invalidate, carrying the page address;
- a PC redirect, which also tells the pipeline to drop its delay-slot flag.

Top module: `spr_access_unit`

## Requirements
- R1: The address splits into group = addr[15:11] and index = addr[10:0]. A read of any address that maps to no register returns `acc_dest_old` unchanged; examples are group 10 index 2 and group 3.
- R2: Group 0 indices 1, 2, 3 and 4 are read-only configuration words with the parameter values UNITS_VAL, CPUCFG_VAL, DMMUCFG_VAL and IMMUCFG_VAL. Writes to them have no effect.
- R3: Group 0 index 0 (version, reset VER_RESET), 11 (vector base), 18 (previous PC), 32 (exception PC), 48 (exception address) and 64 (exception status) store the written word and read it back.
- R4: Group 0 index 17 is the status word, reset value 1, which drives `sr_value`. A write that changes bit 0 (supervisor), bit 5 (data translation enable) or bit 6 (instruction translation enable) raises `tlb_flush_all` in the next cycle. A write that changes none of these bits does not.
- R5: In group 1 (data) and group 2 (instruction), index 512+e is the match word and index 640+e is the translate word of way-0 entry e, for e below TLB_ENTRIES (64). Each word is stored and read back.
- R6: A match write whose bit 0 is 0 raises `page_inval` in the next cycle. `page_inval_addr` then equals the entry's previous match word with its low PAGE_BITS (13) bits cleared, and `page_inval_instr` is 1 for group 2 and 0 for group 1. A match write with bit 0 equal to 1 raises no pulse.
- R7: The following indices in groups 1 and 2 are accepted but ignored: 768 to 1535, and the way-0 indices beyond entry TLB_ENTRIES-1 (576 to 639 and 704 to 767). Reads of them return `acc_dest_old`, and writes to them leave every way-0 entry unchanged.
- R8: Group 5 index 1 reads and writes the low 32 bits of the 64-bit accumulator, and index 2 reads and writes the high 32 bits. A write to one half leaves the other half unchanged.
- R9: A write to group 9 index 0 ORs the written word into the interrupt mask. The mask resets to 0.
- R10: Interrupt status (group 9 index 2) sets the bits given by `pic_raise` on each clock. A write to it clears every bit written as 1.
- R11: A read of group 0 index 16 returns `cur_pc`. A write to it with a value different from `cur_pc` raises `pc_redirect` in the next cycle, with `pc_target` equal to the written value. A write equal to `cur_pc` raises nothing.
- R12: Group 10 indices 0 and 1 belong to the timer. During a valid write, `tmr_wr` is 1 in the same cycle, with `tmr_idx` equal to the index and `tmr_wdata` equal to the data. A read returns `tmr_rdata`.
- R13: The outputs `tlb_flush_all`, `page_inval` and `pc_redirect` are 0 after reset. Each one is high for only the single cycle after the valid write that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = move-to, 0 = move-from |
| acc_addr | input | 16 | Special-register address |
| acc_wdata | input | 32 | Write data |
| acc_dest_old | input | 32 | Previous destination value, returned for unmapped reads |
| acc_rdata | output | 32 | Read data (combinational) |
| cur_pc | input | 32 | Current PC of the accessing instruction |
| pic_raise | input | 32 | Interrupt lines that set status bits |
| tmr_rdata | input | 32 | Read data from the timer block |
| tmr_wr | output | 1 | Timer write strobe |
| tmr_idx | output | 1 | Timer register index |
| tmr_wdata | output | 32 | Timer write data |
| sr_value | output | 32 | Current status word |
| tlb_flush_all | output | 1 | Full flush pulse |
| page_inval | output | 1 | Page invalidate pulse |
| page_inval_instr | output | 1 | Page invalidate targets the instruction side |
| page_inval_addr | output | 32 | Page address to invalidate |
| pc_redirect | output | 1 | PC redirect pulse; also clears the delay-slot flag |
| pc_target | output | 32 | Redirect target |

## Verification
The checker relies on `cur_pc` being stable while a next-PC write is presented. It also relies on `acc_write` being meaningful only while `acc_valid` is high, so every pulse it checks is traced back to a valid write in the previous cycle. The bench keeps within these assumptions: it changes inputs only on falling edges, holds `cur_pc` constant across each access, and drops the strobe after exactly one rising edge. The page-address check depends on the previous match word, so the bench always writes a known match value first and only then clears its valid bit.

// File: rtl/spr_pkg.sv
// Shared types for the special-register access unit.
// Assumes a 16-bit address: five group bits above eleven index bits.
package spr_pkg;
    localparam int GRP_W = 5;
    localparam int IDX_W = 11;
    localparam int SR_SM_BIT  = 0;
    localparam int SR_DME_BIT = 5;
    localparam int SR_IME_BIT = 6;

    typedef enum logic [4:0] {
        SEL_NONE, SEL_VER, SEL_UNITS, SEL_CPUCFG, SEL_DMMUCFG, SEL_IMMUCFG,
        SEL_VBASE, SEL_NPC, SEL_STATUS, SEL_PPC, SEL_EPC, SEL_EADDR, SEL_ESTAT,
        SEL_DTLB_MATCH, SEL_DTLB_XLATE, SEL_ITLB_MATCH, SEL_ITLB_XLATE,
        SEL_TLB_IGNORED, SEL_ACC_LO, SEL_ACC_HI, SEL_IRQ_MASK, SEL_IRQ_STAT,
        SEL_TIMER
    } spr_sel_e;
endpackage

// File: rtl/spr_addr_decode.sv
// Address decoder: turns a special-register address into a register select
// and a way-0 entry number. Purely combinational.
// Assumes TLB_ENTRIES is a power of two and no larger than 128.
module spr_addr_decode
    import spr_pkg::*;
#(
    parameter int TLB_ENTRIES = 64,
    localparam int EW = $clog2(TLB_ENTRIES)
) (
    input  logic [15:0]   addr,
    output spr_sel_e      sel,
    output logic [EW-1:0] entry
);
    localparam logic [IDX_W-1:0] MATCH_LO = IDX_W'(512);
    localparam logic [IDX_W-1:0] MATCH_HI = IDX_W'(512 + TLB_ENTRIES);
    localparam logic [IDX_W-1:0] XLATE_LO = IDX_W'(640);
    localparam logic [IDX_W-1:0] XLATE_HI = IDX_W'(640 + TLB_ENTRIES);
    localparam logic [IDX_W-1:0] WAY0_END = IDX_W'(768);

    logic [GRP_W-1:0] grp;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] off_m;
    logic [IDX_W-1:0] off_t;

    assign grp   = addr[15:11];
    assign idx   = addr[10:0];
    assign off_m = idx - MATCH_LO;
    assign off_t = idx - XLATE_LO;

    // Map group and index onto one register select.
    always_comb begin
        sel   = SEL_NONE;
        entry = '0;
        case (grp)
            5'd0: begin
                case (idx)
                    11'd0:   sel = SEL_VER;
                    11'd1:   sel = SEL_UNITS;
                    11'd2:   sel = SEL_CPUCFG;
                    11'd3:   sel = SEL_DMMUCFG;
                    11'd4:   sel = SEL_IMMUCFG;
                    11'd11:  sel = SEL_VBASE;
                    11'd16:  sel = SEL_NPC;
                    11'd17:  sel = SEL_STATUS;
                    11'd18:  sel = SEL_PPC;
                    11'd32:  sel = SEL_EPC;
                    11'd48:  sel = SEL_EADDR;
                    11'd64:  sel = SEL_ESTAT;
                    default: sel = SEL_NONE;
                endcase
            end
            5'd1, 5'd2: begin
                if (idx >= MATCH_LO && idx < MATCH_HI) begin
                    sel   = (grp == 5'd1) ? SEL_DTLB_MATCH : SEL_ITLB_MATCH;
                    entry = off_m[EW-1:0];
                end else if (idx >= XLATE_LO && idx < XLATE_HI) begin
                    sel   = (grp == 5'd1) ? SEL_DTLB_XLATE : SEL_ITLB_XLATE;
                    entry = off_t[EW-1:0];
                end else if (idx >= MATCH_HI && idx < WAY0_END) begin
                    sel = SEL_TLB_IGNORED;
                end else if (idx >= WAY0_END && idx <= 11'd1535) begin
                    sel = SEL_TLB_IGNORED;
                end
            end
            5'd5: begin
                if (idx == 11'd1)      sel = SEL_ACC_LO;
                else if (idx == 11'd2) sel = SEL_ACC_HI;
            end
            5'd9: begin
                if (idx == 11'd0)      sel = SEL_IRQ_MASK;
                else if (idx == 11'd2) sel = SEL_IRQ_STAT;
            end
            5'd10: begin
                if (idx <= 11'd1) sel = SEL_TIMER;
            end
            default: sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/spr_tlb_way0.sv
// One way-0 translation array: match and translate words per entry.
// A match write with bit 0 low raises a registered page-invalidate pulse,
// carrying the entry's previous match word masked to a page address.
module spr_tlb_way0 #(
    parameter int DW          = 32,
    parameter int TLB_ENTRIES = 64,
    parameter int PAGE_BITS   = 13,
    localparam int EW = $clog2(TLB_ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_match,
    input  logic          wr_xlate,
    input  logic [EW-1:0] entry,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_match,
    output logic [DW-1:0] rd_xlate,
    output logic          inval_q,
    output logic [DW-1:0] inval_addr_q
);
    localparam logic [DW-1:0] OFFS_MASK = (DW'(1) << PAGE_BITS) - DW'(1);

    logic [DW-1:0] match_q [TLB_ENTRIES];
    logic [DW-1:0] xlate_q [TLB_ENTRIES];

    assign rd_match = match_q[entry];
    assign rd_xlate = xlate_q[entry];

    // Store entry words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TLB_ENTRIES; i++) begin
                match_q[i] <= '0;
                xlate_q[i] <= '0;
            end
        end else begin
            if (wr_match) match_q[entry] <= wdata;
            if (wr_xlate) xlate_q[entry] <= wdata;
        end
    end

    // Page-invalidate pulse, using the match word from before the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inval_q      <= 1'b0;
            inval_addr_q <= '0;
        end else begin
            inval_q      <= wr_match && !wdata[0];
            inval_addr_q <= match_q[entry] & ~OFFS_MASK;
        end
    end
endmodule

// File: rtl/spr_core_regs.sv
// System, accumulator and interrupt registers, with the status-change flush
// pulse and the next-PC redirect pulse. Read data covers only its own selects.
module spr_core_regs
    import spr_pkg::*;
#(
    parameter int          DW          = 32,
    parameter logic [31:0] VER_RESET   = 32'h1200_0001,
    parameter logic [31:0] UNITS_VAL   = 32'h0000_0619,
    parameter logic [31:0] CPUCFG_VAL  = 32'h0000_0020,
    parameter logic [31:0] DMMUCFG_VAL = 32'h0000_0018,
    parameter logic [31:0] IMMUCFG_VAL = 32'h0000_0018
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  spr_sel_e      sel,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] cur_pc,
    input  logic [DW-1:0] pic_raise,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] sr_q,
    output logic          flush_q,
    output logic          redirect_q,
    output logic [DW-1:0] target_q
);
    localparam logic [DW-1:0] FLUSH_MASK =
        (DW'(1) << SR_SM_BIT) | (DW'(1) << SR_DME_BIT) | (DW'(1) << SR_IME_BIT);

    logic [DW-1:0]   ver_q, vbase_q, ppc_q, epc_q, eaddr_q, estat_q;
    logic [DW-1:0]   mask_q, stat_q;
    logic [2*DW-1:0] acc_q;

    // Plain-store registers and the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ver_q   <= DW'(VER_RESET);
            vbase_q <= '0;
            ppc_q   <= '0;
            epc_q   <= '0;
            eaddr_q <= '0;
            estat_q <= '0;
            sr_q    <= DW'(1);
        end else if (we) begin
            case (sel)
                SEL_VER:    ver_q   <= wdata;
                SEL_VBASE:  vbase_q <= wdata;
                SEL_PPC:    ppc_q   <= wdata;
                SEL_EPC:    epc_q   <= wdata;
                SEL_EADDR:  eaddr_q <= wdata;
                SEL_ESTAT:  estat_q <= wdata;
                SEL_STATUS: sr_q    <= wdata;
                default: ;
            endcase
        end
    end

    // Accumulator half deposit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (we && sel == SEL_ACC_LO) begin
            acc_q[DW-1:0] <= wdata;
        end else if (we && sel == SEL_ACC_HI) begin
            acc_q[2*DW-1:DW] <= wdata;
        end
    end

    // Interrupt mask (OR-in) and status (set by lines, write-one-to-clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            stat_q <= '0;
        end else begin
            if (we && sel == SEL_IRQ_MASK) mask_q <= mask_q | wdata;
            stat_q <= (stat_q & ~((we && sel == SEL_IRQ_STAT) ? wdata : '0)) | pic_raise;
        end
    end

    // Side-effect pulses: flush on translation/mode change, redirect on new PC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_q    <= 1'b0;
            redirect_q <= 1'b0;
            target_q   <= '0;
        end else begin
            flush_q    <= we && sel == SEL_STATUS && (((wdata ^ sr_q) & FLUSH_MASK) != '0);
            redirect_q <= we && sel == SEL_NPC && (wdata != cur_pc);
            if (we && sel == SEL_NPC) target_q <= wdata;
        end
    end

    // Read mux for the registers held here.
    always_comb begin
        case (sel)
            SEL_VER:      rdata = ver_q;
            SEL_UNITS:    rdata = DW'(UNITS_VAL);
            SEL_CPUCFG:   rdata = DW'(CPUCFG_VAL);
            SEL_DMMUCFG:  rdata = DW'(DMMUCFG_VAL);
            SEL_IMMUCFG:  rdata = DW'(IMMUCFG_VAL);
            SEL_VBASE:    rdata = vbase_q;
            SEL_NPC:      rdata = cur_pc;
            SEL_STATUS:   rdata = sr_q;
            SEL_PPC:      rdata = ppc_q;
            SEL_EPC:      rdata = epc_q;
            SEL_EADDR:    rdata = eaddr_q;
            SEL_ESTAT:    rdata = estat_q;
            SEL_ACC_LO:   rdata = acc_q[DW-1:0];
            SEL_ACC_HI:   rdata = acc_q[2*DW-1:DW];
            SEL_IRQ_MASK: rdata = mask_q;
            SEL_IRQ_STAT: rdata = stat_q;
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/spr_access_unit.sv
// Top of the special-register access unit. Decodes one access per cycle,
// routes it to the system registers, the two way-0 arrays or the timer,
// and merges the side-effect pulses. Assumes at most one access per cycle.
module spr_access_unit
    import spr_pkg::*;
#(
    parameter int DW          = 32,
    parameter int TLB_ENTRIES = 64,
    parameter int PAGE_BITS   = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [15:0]   acc_addr,
    input  logic [DW-1:0] acc_wdata,
    input  logic [DW-1:0] acc_dest_old,
    output logic [DW-1:0] acc_rdata,
    input  logic [DW-1:0] cur_pc,
    input  logic [DW-1:0] pic_raise,
    input  logic [DW-1:0] tmr_rdata,
    output logic          tmr_wr,
    output logic          tmr_idx,
    output logic [DW-1:0] tmr_wdata,
    output logic [DW-1:0] sr_value,
    output logic          tlb_flush_all,
    output logic          page_inval,
    output logic          page_inval_instr,
    output logic [DW-1:0] page_inval_addr,
    output logic          pc_redirect,
    output logic [DW-1:0] pc_target
);
    localparam int EW = $clog2(TLB_ENTRIES);

    spr_sel_e      sel;
    logic [EW-1:0] entry;
    logic          we;
    logic [DW-1:0] core_rdata;
    logic [DW-1:0] way_match [2];
    logic [DW-1:0] way_xlate [2];
    logic [DW-1:0] way_iaddr [2];
    logic          way_inval [2];

    assign we = acc_valid && acc_write;

    spr_addr_decode #(.TLB_ENTRIES(TLB_ENTRIES)) u_dec (
        .addr  (acc_addr),
        .sel   (sel),
        .entry (entry)
    );

    spr_core_regs #(.DW(DW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (we),
        .sel        (sel),
        .wdata      (acc_wdata),
        .cur_pc     (cur_pc),
        .pic_raise  (pic_raise),
        .rdata      (core_rdata),
        .sr_q       (sr_value),
        .flush_q    (tlb_flush_all),
        .redirect_q (pc_redirect),
        .target_q   (pc_target)
    );

    // Way 0 of the data array (w = 0) and the instruction array (w = 1).
    for (genvar w = 0; w < 2; w++) begin : g_way0
        localparam spr_sel_e MSEL = (w == 0) ? SEL_DTLB_MATCH : SEL_ITLB_MATCH;
        localparam spr_sel_e XSEL = (w == 0) ? SEL_DTLB_XLATE : SEL_ITLB_XLATE;
        spr_tlb_way0 #(
            .DW(DW), .TLB_ENTRIES(TLB_ENTRIES), .PAGE_BITS(PAGE_BITS)
        ) u_way (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_match     (we && sel == MSEL),
            .wr_xlate     (we && sel == XSEL),
            .entry        (entry),
            .wdata        (acc_wdata),
            .rd_match     (way_match[w]),
            .rd_xlate     (way_xlate[w]),
            .inval_q      (way_inval[w]),
            .inval_addr_q (way_iaddr[w])
        );
    end

    assign page_inval       = way_inval[0] || way_inval[1];
    assign page_inval_instr = way_inval[1];
    assign page_inval_addr  = way_inval[1] ? way_iaddr[1] : way_iaddr[0];

    assign tmr_wr    = we && sel == SEL_TIMER;
    assign tmr_idx   = acc_addr[0];
    assign tmr_wdata = acc_wdata;

    // Final read mux; unmapped and ignored addresses pass the old value through.
    always_comb begin
        case (sel)
            SEL_DTLB_MATCH:            acc_rdata = way_match[0];
            SEL_DTLB_XLATE:            acc_rdata = way_xlate[0];
            SEL_ITLB_MATCH:            acc_rdata = way_match[1];
            SEL_ITLB_XLATE:            acc_rdata = way_xlate[1];
            SEL_TIMER:                 acc_rdata = tmr_rdata;
            SEL_NONE, SEL_TLB_IGNORED: acc_rdata = acc_dest_old;
            default:                   acc_rdata = core_rdata;
        endcase
    end
endmodule

// File: rtl/spr_access_chk.sv
// Property checker for the special-register access unit, bound to the top.
module spr_access_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [15:0] acc_addr,
    input logic [31:0] acc_wdata,
    input logic [31:0] cur_pc,
    input logic        tmr_wr,
    input logic [31:0] sr_value,
    input logic        tlb_flush_all,
    input logic        page_inval,
    input logic [31:0] page_inval_addr,
    input logic        pc_redirect,
    input logic [31:0] pc_target
);
    // R4
    flush_on_mode_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_addr == 16'h0011 &&
         ((acc_wdata ^ sr_value) & 32'h0000_0061) != 32'h0) |=> tlb_flush_all);

    // R4
    status_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_write && acc_addr == 16'h0011) |=> $stable(sr_value));

    // R11
    redirect_new_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_addr == 16'h0010 && acc_wdata != cur_pc)
        |=> (pc_redirect && pc_target == $past(acc_wdata)));

    // R11
    no_redirect_same_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_addr == 16'h0010 && acc_wdata == cur_pc)
        |=> !pc_redirect);

    // R13
    flush_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush_all |-> $past(acc_valid && acc_write));

    // R13
    inval_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_inval |-> $past(acc_valid && acc_write));

    // R6
    inval_page_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_inval |-> page_inval_addr[12:0] == 13'h0);

    // R12
    timer_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wr |-> (acc_valid && acc_write && acc_addr[15:11] == 5'd10));
endmodule

bind spr_access_unit spr_access_chk u_spr_access_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .acc_valid       (acc_valid),
    .acc_write       (acc_write),
    .acc_addr        (acc_addr),
    .acc_wdata       (acc_wdata),
    .cur_pc          (cur_pc),
    .tmr_wr          (tmr_wr),
    .sr_value        (sr_value),
    .tlb_flush_all   (tlb_flush_all),
    .page_inval      (page_inval),
    .page_inval_addr (page_inval_addr),
    .pc_redirect     (pc_redirect),
    .pc_target       (pc_target)
);

// File: tb/test_spr_access_unit.sv
// Directed bench for the special-register access unit.
module test_spr_access_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_dest_old = '0;
    logic [31:0] acc_rdata;
    logic [31:0] cur_pc = 32'h0000_0100;
    logic [31:0] pic_raise = '0;
    logic [31:0] tmr_rdata = '0;
    logic        tmr_wr, tmr_idx;
    logic [31:0] tmr_wdata, sr_value, page_inval_addr, pc_target;
    logic        tlb_flush_all, page_inval, page_inval_instr, pc_redirect;

    int total = 0;
    int fails = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    spr_access_unit i_spr_access_unit (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_dest_old(acc_dest_old),
        .acc_rdata(acc_rdata), .cur_pc(cur_pc), .pic_raise(pic_raise),
        .tmr_rdata(tmr_rdata), .tmr_wr(tmr_wr), .tmr_idx(tmr_idx),
        .tmr_wdata(tmr_wdata), .sr_value(sr_value), .tlb_flush_all(tlb_flush_all),
        .page_inval(page_inval), .page_inval_instr(page_inval_instr),
        .page_inval_addr(page_inval_addr), .pc_redirect(pc_redirect),
        .pc_target(pc_target)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One write; on return, the pulses it caused are visible.
    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] dest, output logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_dest_old = dest;
        #1 d = acc_rdata;
        acc_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R13 flush after reset", {31'b0, tlb_flush_all}, 32'h0);
        chk("R13 inval after reset", {31'b0, page_inval}, 32'h0);
        chk("R13 redirect after reset", {31'b0, pc_redirect}, 32'h0);
        rd(16'h0011, 32'h0, rv); chk("R4 status reset", rv, 32'h1);
        rd(16'h0000, 32'h0, rv); chk("R3 version reset", rv, 32'h1200_0001);
        rd(16'h5002, 32'h5A5A_0001, rv); chk("R1 unmapped timer idx", rv, 32'h5A5A_0001);
        rd(16'h1805, 32'h0BAD_F00D, rv); chk("R1 unmapped group", rv, 32'h0BAD_F00D);
    endtask

    task automatic t_sys();
        wr(16'h000B, 32'h0000_2000); rd(16'h000B, 0, rv); chk("R3 vector base", rv, 32'h0000_2000);
        wr(16'h0020, 32'h0000_4444); rd(16'h0020, 0, rv); chk("R3 exception pc", rv, 32'h0000_4444);
        wr(16'h0040, 32'h0000_0777); rd(16'h0040, 0, rv); chk("R3 exception status", rv, 32'h0000_0777);
        wr(16'h0012, 32'h0000_0330); rd(16'h0012, 0, rv); chk("R3 previous pc", rv, 32'h0000_0330);
        wr(16'h0001, 32'hFFFF_FFFF); rd(16'h0001, 0, rv); chk("R2 units read-only", rv, 32'h0000_0619);
        rd(16'h0002, 0, rv); chk("R2 cpu config", rv, 32'h0000_0020);
    endtask

    task automatic t_status();
        wr(16'h0011, 32'h0000_0001); chk("R4 no flush same bits", {31'b0, tlb_flush_all}, 32'h0);
        wr(16'h0011, 32'h0000_0021); chk("R4 flush on data enable", {31'b0, tlb_flush_all}, 32'h1);
        @(negedge clk); chk("R13 flush one cycle", {31'b0, tlb_flush_all}, 32'h0);
        chk("R4 status value", sr_value, 32'h0000_0021);
        wr(16'h0011, 32'h0000_8021); chk("R4 no flush other bit", {31'b0, tlb_flush_all}, 32'h0);
        wr(16'h0011, 32'h0000_8020); chk("R4 flush on supervisor", {31'b0, tlb_flush_all}, 32'h1);
    endtask

    task automatic t_tlb();
        wr(16'h0A05, 32'h1234_5001); chk("R6 valid match no inval", {31'b0, page_inval}, 32'h0);
        wr(16'h0A85, 32'h0000_ABC3);
        rd(16'h0A05, 0, rv); chk("R5 data match", rv, 32'h1234_5001);
        rd(16'h0A85, 0, rv); chk("R5 data translate", rv, 32'h0000_ABC3);
        wr(16'h0A05, 32'h0000_0000);
        chk("R6 data inval pulse", {31'b0, page_inval}, 32'h1);
        chk("R6 data inval addr", page_inval_addr, 32'h1234_4000);
        chk("R6 data side", {31'b0, page_inval_instr}, 32'h0);
        @(negedge clk); chk("R13 inval one cycle", {31'b0, page_inval}, 32'h0);
        wr(16'h1203, 32'hABCD_E001);
        wr(16'h1203, 32'h0000_0010);
        chk("R6 instr inval pulse", {31'b0, page_inval}, 32'h1);
        chk("R6 instr inval addr", page_inval_addr, 32'hABCD_E000);
        chk("R6 instr side", {31'b0, page_inval_instr}, 32'h1);
        wr(16'h0A00, 32'h0000_1111);
        wr(16'h0A40, 32'h9999_9999);
        rd(16'h0A40, 32'h0000_00EE, rv); chk("R7 way0 beyond entries read", rv, 32'h0000_00EE);
        rd(16'h0A00, 0, rv); chk("R7 entry 0 untouched", rv, 32'h0000_1111);
        wr(16'h0B00, 32'h7777_7777);
        rd(16'h0B00, 32'h0000_0042, rv); chk("R7 way1 ignored read", rv, 32'h0000_0042);
        rd(16'h0DFF, 32'h0000_0043, rv); chk("R7 last ignored index", rv, 32'h0000_0043);
        rd(16'h0A00, 0, rv); chk("R7 entry 0 still untouched", rv, 32'h0000_1111);
    endtask

    task automatic t_acc();
        wr(16'h2801, 32'h1111_1111);
        wr(16'h2802, 32'h2222_2222);
        rd(16'h2801, 0, rv); chk("R8 low half", rv, 32'h1111_1111);
        wr(16'h2801, 32'h3333_3333);
        rd(16'h2802, 0, rv); chk("R8 high half kept", rv, 32'h2222_2222);
        rd(16'h2801, 0, rv); chk("R8 low half rewritten", rv, 32'h3333_3333);
    endtask

    task automatic t_pic();
        wr(16'h4800, 32'h0000_000F);
        wr(16'h4800, 32'h0000_00F0);
        rd(16'h4800, 0, rv); chk("R9 mask or", rv, 32'h0000_00FF);
        @(negedge clk); pic_raise = 32'h0000_00A5;
        @(negedge clk); pic_raise = 32'h0;
        rd(16'h4802, 0, rv); chk("R10 status raised", rv, 32'h0000_00A5);
        wr(16'h4802, 32'h0000_0005);
        rd(16'h4802, 0, rv); chk("R10 status w1c", rv, 32'h0000_00A0);
    endtask

    task automatic t_npc();
        rd(16'h0010, 0, rv); chk("R11 npc read", rv, 32'h0000_0100);
        wr(16'h0010, 32'h0000_0100); chk("R11 same pc no redirect", {31'b0, pc_redirect}, 32'h0);
        wr(16'h0010, 32'h0000_0200);
        chk("R11 redirect pulse", {31'b0, pc_redirect}, 32'h1);
        chk("R11 redirect target", pc_target, 32'h0000_0200);
        @(negedge clk); chk("R13 redirect one cycle", {31'b0, pc_redirect}, 32'h0);
    endtask

    task automatic t_tmr();
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 16'h5001; acc_wdata = 32'h7;
        #1;
        chk("R12 timer strobe", {31'b0, tmr_wr}, 32'h1);
        chk("R12 timer index", {31'b0, tmr_idx}, 32'h1);
        chk("R12 timer data", tmr_wdata, 32'h7);
        @(negedge clk); acc_valid = 1'b0; acc_write = 1'b0;
        tmr_rdata = 32'h0000_CAFE;
        rd(16'h5000, 0, rv); chk("R12 timer read", rv, 32'h0000_CAFE);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sys();
        t_status();
        t_tlb();
        t_acc();
        t_pic();
        t_npc();
        t_tmr();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule